// File: doc/BRIEF.md
# Bit-Sliced Eight-Bit ALU Datapath

This block is an eight-bit arithmetic and logic datapath built from identical one-bit slices. Each slice stores one bit of operand register A, one bit of operand register B and one bit of the Result register. Each slice also computes one bit of the selected function. A separate look-ahead unit takes a generate and a propagate term from every slice and returns all carries in the same cycle. A status unit keeps zero, carry-out and signed-overflow flags.

A host moves data over a data bus that is modelled as separate input and output ports. A transfer command picks one of three register moves: bus to A, Result to bus, or Result to A. A separate strobe loads B from the bus. When the host raises the operation strobe, the selected operation is written into Result at the next clock edge. Set-less-than takes its decision from the top slice and hands it to the bottom slice.

Top module: `bitslice_alu`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears A, B, Result and all three flags to 0.
- R2: With `alu_go` high at an edge, `alu_op` codes 0 (AND), 1 (OR), 2 (NOR) and 3 (XOR) write the bitwise function of A and B into Result. The new value is visible after that edge.
- R3: Code 4 (ADD) writes A+B modulo 256 into Result. It sets the carry flag to the carry out of bit 7 and the overflow flag to signed two's-complement overflow.
- R4: Code 5 (SUB) writes A-B modulo 256 into Result. It sets carry to 1 exactly when A >= B as unsigned numbers, and sets overflow to signed overflow of the subtraction.
- R5: Code 6 (SLT) writes 1 into Result when A < B as signed eight-bit numbers, and 0 otherwise, including the cases where A-B overflows. Bits 7..1 are always 0.
- R6: On every Result load, the zero flag becomes 1 exactly when the new Result is 0. For codes 0-3 and 6, the carry and overflow flags become 0.
- R7: When `alu_go` is low, or `alu_op` is 7, Result and all flags keep their values.
- R8: Transfer code 2'b01 loads A from `bus_in` at the edge.
- R9: While the transfer code is 2'b10, `bus_out` shows Result combinationally. For any other code, `bus_out` is 0.
- R10: Transfer code 2'b11 loads A with the value Result held before the edge. An operation issued at the same edge uses the old A.
- R11: `load_b` high loads B from `bus_in` at the edge. A and B can be loaded at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 8 | Data bus into the block |
| bus_out | output | 8 | Data bus out of the block (Result when the transfer code is 2'b10, else 0) |
| load_b | input | 1 | Load B from bus_in |
| xfer | input | 2 | Transfer command: 00 none, 01 bus to A, 10 Result to bus, 11 Result to A |
| alu_go | input | 1 | Issue the operation in alu_op |
| alu_op | input | 3 | Operation code (0 AND, 1 OR, 2 NOR, 3 XOR, 4 ADD, 5 SUB, 6 SLT, 7 none) |
| result | output | 8 | Result register |
| reg_a | output | 8 | Register A |
| reg_b | output | 8 | Register B |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry-out flag |
| flag_ovf | output | 1 | Signed overflow flag |

## Verification
Every register result, flag and A/B move is due one clock edge after its stimulus, because each passes through exactly one flip-flop. `bus_out` is due in the same cycle as the transfer code. The bench drives inputs on the falling edge. It checks `bus_out` one nanosecond later, before any rising edge. After the rising edge it compares every registered output with a behavioural model at the following falling edge. The model advances exactly once per rising edge, so a result that lands a cycle early or late shows up as a mismatch.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int unsigned OP_W = 3;

    localparam logic [OP_W-1:0] OPC_AND  = 3'd0;
    localparam logic [OP_W-1:0] OPC_OR   = 3'd1;
    localparam logic [OP_W-1:0] OPC_NOR  = 3'd2;
    localparam logic [OP_W-1:0] OPC_XOR  = 3'd3;
    localparam logic [OP_W-1:0] OPC_ADD  = 3'd4;
    localparam logic [OP_W-1:0] OPC_SUB  = 3'd5;
    localparam logic [OP_W-1:0] OPC_SLT  = 3'd6;
    localparam logic [OP_W-1:0] OPC_NONE = 3'd7;

    localparam logic [1:0] XF_NONE    = 2'b00;
    localparam logic [1:0] XF_BUS2A   = 2'b01;
    localparam logic [1:0] XF_RES2BUS = 2'b10;
    localparam logic [1:0] XF_RES2A   = 2'b11;

    typedef struct packed {
        logic zero;
        logic carry;
        logic ovf;
    } alu_flags_t;

    typedef struct packed {
        logic a;
        logic b;
        logic r;
    } slice_regs_t;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_bit,
    input  logic            a_from_bus,
    input  logic            a_from_res,
    input  logic            b_load,
    input  logic            r_load,
    input  logic [OP_W-1:0] op,
    input  logic            b_inv,
    input  logic            c_in,
    input  logic            slt_in,
    output logic            a_bit,
    output logic            b_bit,
    output logic            r_bit,
    output logic            gen,
    output logic            prop,
    output logic            sum,
    output logic            fn_bit
);
    slice_regs_t st_q, st_d;
    logic        b_eff;

    always_comb begin
        b_eff = st_q.b ^ b_inv;
        gen   = st_q.a & b_eff;
        prop  = st_q.a ^ b_eff;
        sum   = prop ^ c_in;
        case (op)
            OPC_AND: fn_bit = st_q.a & st_q.b;
            OPC_OR:  fn_bit = st_q.a | st_q.b;
            OPC_NOR: fn_bit = ~(st_q.a | st_q.b);
            OPC_XOR: fn_bit = st_q.a ^ st_q.b;
            OPC_ADD: fn_bit = sum;
            OPC_SUB: fn_bit = sum;
            OPC_SLT: fn_bit = slt_in;
            default: fn_bit = st_q.r;
        endcase

        st_d = st_q;
        if (a_from_bus)      st_d.a = bus_bit;
        else if (a_from_res) st_d.a = st_q.r;
        if (b_load)          st_d.b = bus_bit;
        if (r_load)          st_d.r = fn_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign a_bit = st_q.a;
    assign b_bit = st_q.b;
    assign r_bit = st_q.r;

    a_r8_bus_to_a: assert property (@(posedge clk) disable iff (rst)
        a_from_bus |=> a_bit == $past(bus_bit));
endmodule

// File: rtl/alu_lookahead.sv
module alu_lookahead #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] g,
    input  logic [W-1:0] p,
    input  logic         cin,
    output logic [W:0]   c
);
    always_comb begin
        c[0] = cin;
        for (int i = 1; i <= W; i++) begin
            logic acc;
            logic term;
            term = cin;
            for (int k = 0; k < i; k++) term = term & p[k];
            acc = term;
            for (int j = 0; j < i; j++) begin
                term = g[j];
                for (int k = j + 1; k < i; k++) term = term & p[k];
                acc = acc | term;
            end
            c[i] = acc;
        end
    end
endmodule

// File: rtl/alu_status.sv
module alu_status
    import alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    res_next,
    input  logic            c_out,
    input  logic            ovf_in,
    output alu_flags_t      flags
);
    alu_flags_t fl_q, fl_d;
    logic       arith;

    always_comb begin
        arith = (op == OPC_ADD) || (op == OPC_SUB);
        fl_d  = fl_q;
        if (load) begin
            fl_d.zero  = (res_next == '0);
            fl_d.carry = arith & c_out;
            fl_d.ovf   = arith & ovf_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '0;
        else     fl_q <= fl_d;
    end

    assign flags = fl_q;

    a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(flags));
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    bus_in,
    output logic [W-1:0]    bus_out,
    input  logic            load_b,
    input  logic [1:0]      xfer,
    input  logic            alu_go,
    input  logic [OP_W-1:0] alu_op,
    output logic [W-1:0]    result,
    output logic [W-1:0]    reg_a,
    output logic [W-1:0]    reg_b,
    output logic            flag_zero,
    output logic            flag_carry,
    output logic            flag_ovf
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] gen_v, prop_v, sum_v, fn_v, slt_v;
    logic [W:0]   carry_v;
    logic         inv_b, ld_res, ovf, less;
    alu_flags_t   flags;

    assign inv_b  = (alu_op == OPC_SUB) || (alu_op == OPC_SLT);
    assign ld_res = alu_go && (alu_op != OPC_NONE);
    assign ovf    = carry_v[W] ^ carry_v[MSB];
    assign less   = sum_v[MSB] ^ ovf;

    generate
        for (genvar i = 0; i < W; i++) begin : g_slice
            if (i == 0) begin : g_lsb
                assign slt_v[i] = less;
            end else begin : g_upper
                assign slt_v[i] = 1'b0;
            end
            alu_bit_slice u_slice (
                .clk        (clk),
                .rst        (rst),
                .bus_bit    (bus_in[i]),
                .a_from_bus (xfer == XF_BUS2A),
                .a_from_res (xfer == XF_RES2A),
                .b_load     (load_b),
                .r_load     (ld_res),
                .op         (alu_op),
                .b_inv      (inv_b),
                .c_in       (carry_v[i]),
                .slt_in     (slt_v[i]),
                .a_bit      (reg_a[i]),
                .b_bit      (reg_b[i]),
                .r_bit      (result[i]),
                .gen        (gen_v[i]),
                .prop       (prop_v[i]),
                .sum        (sum_v[i]),
                .fn_bit     (fn_v[i])
            );
        end
    endgenerate

    alu_lookahead #(.W(W)) u_cla (
        .g   (gen_v),
        .p   (prop_v),
        .cin (inv_b),
        .c   (carry_v)
    );

    alu_status #(.W(W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_res),
        .op       (alu_op),
        .res_next (fn_v),
        .c_out    (carry_v[W]),
        .ovf_in   (ovf),
        .flags    (flags)
    );

    assign flag_zero  = flags.zero;
    assign flag_carry = flags.carry;
    assign flag_ovf   = flags.ovf;
    assign bus_out    = (xfer == XF_RES2BUS) ? result : '0;

    a_r9_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        xfer != XF_RES2BUS |-> bus_out == '0);
    a_r5_slt_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (ld_res && alu_op == OPC_SLT) |=> result[MSB:1] == '0);
    a_r6_zero_tracks: assert property (@(posedge clk) disable iff (rst)
        ld_res |=> flag_zero == (result == '0));
    a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_res |=> $stable(result));
    a_r10_res_to_a: assert property (@(posedge clk) disable iff (rst)
        xfer == XF_RES2A |=> reg_a == $past(result));
    a_r11_load_b: assert property (@(posedge clk) disable iff (rst)
        load_b |=> reg_b == $past(bus_in));
endmodule

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb;
    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] bus_in = 0;
    logic [7:0] bus_out;
    logic       load_b = 0;
    logic [1:0] xfer = 0;
    logic       alu_go = 0;
    logic [2:0] alu_op = 0;
    logic [7:0] result, reg_a, reg_b;
    logic       flag_zero, flag_carry, flag_ovf;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] m_a = 0, m_b = 0, m_r = 0;
    logic       m_z = 0, m_c = 0, m_v = 0;
    string      last_tag = "R1";

    always #2 clk = ~clk;

    bitslice_alu u_dut (
        .clk(clk), .rst(rst), .bus_in(bus_in), .bus_out(bus_out),
        .load_b(load_b), .xfer(xfer), .alu_go(alu_go), .alu_op(alu_op),
        .result(result), .reg_a(reg_a), .reg_b(reg_b),
        .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_ovf(flag_ovf)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_state();
        chk(last_tag, "result", result, m_r);
        chk("R6", "zero", flag_zero, m_z);
        chk(last_tag, "carry", flag_carry, m_c);
        chk(last_tag, "ovf", flag_ovf, m_v);
        chk("R8", "reg_a", reg_a, m_a);
        chk("R11", "reg_b", reg_b, m_b);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(bit lb, logic [1:0] xf, bit go, logic [2:0] op, logic [7:0] din);
        logic [7:0] nr, na, nb;
        logic       nz, nc, nv;
        int         sa, sb, sr;
        load_b = lb; xfer = xf; alu_go = go; alu_op = op; bus_in = din;
        #1;
        chk("R9", "bus_out", bus_out, (xf == 2'b10) ? m_r : 8'd0);
        nr = m_r; nz = m_z; nc = m_c; nv = m_v;
        sa = $signed(m_a); sb = $signed(m_b);
        if (go && op != 3'd7) begin
            nc = 0; nv = 0;
            case (op)
                3'd0: begin nr = m_a & m_b;    last_tag = "R2"; end
                3'd1: begin nr = m_a | m_b;    last_tag = "R2"; end
                3'd2: begin nr = ~(m_a | m_b); last_tag = "R2"; end
                3'd3: begin nr = m_a ^ m_b;    last_tag = "R2"; end
                3'd4: begin
                    nr = m_a + m_b; sr = sa + sb;
                    nc = ({1'b0, m_a} + {1'b0, m_b}) > 9'd255;
                    nv = (sr > 127) || (sr < -128);
                    last_tag = "R3";
                end
                3'd5: begin
                    nr = m_a - m_b; sr = sa - sb;
                    nc = (m_a >= m_b);
                    nv = (sr > 127) || (sr < -128);
                    last_tag = "R4";
                end
                default: begin nr = (sa < sb) ? 8'd1 : 8'd0; last_tag = "R5"; end
            endcase
            nz = (nr == 0);
        end else begin
            last_tag = "R7";
        end
        na = m_a;
        if (xf == 2'b01) na = din;
        else if (xf == 2'b11) na = m_r;   // R10: old Result
        nb = lb ? din : m_b;
        @(posedge clk);
        m_a = na; m_b = nb; m_r = nr; m_z = nz; m_c = nc; m_v = nv;
        @(negedge clk);
        compare_state();
    endtask

    task automatic do_reset();
        rst = 1; load_b = 0; xfer = 0; alu_go = 0; alu_op = 0; bus_in = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_a = 0; m_b = 0; m_r = 0; m_z = 0; m_c = 0; m_v = 0;
        last_tag = "R1";
        chk("R1", "result", result, 0);
        chk("R1", "reg_a", reg_a, 0);
        chk("R1", "reg_b", reg_b, 0);
        chk("R1", "flags", {flag_zero, flag_carry, flag_ovf}, 0);
    endtask

    task automatic load_ab(logic [7:0] a, logic [7:0] b);
        step(1'b1, 2'b01, 1'b0, 3'd0, a);   // R8 + R11 same edge
        step(1'b1, 2'b00, 1'b0, 3'd0, b);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        load_ab(8'h7F, 8'h01);
        step(0, 2'b00, 1, 3'd4, 0);          // R3 ADD signed overflow
        step(0, 2'b10, 0, 3'd0, 0);          // R9 Result on bus
        load_ab(8'h00, 8'h00);
        step(0, 2'b00, 1, 3'd5, 0);          // R4 SUB zero, carry 1
        load_ab(8'h80, 8'h01);
        step(0, 2'b00, 1, 3'd6, 0);          // R5 SLT with overflow -> 1
        step(0, 2'b00, 1, 3'd5, 0);          // R4 SUB overflow
        load_ab(8'h7F, 8'h80);
        step(0, 2'b00, 1, 3'd6, 0);          // R5 -> 0
        load_ab(8'hF0, 8'h3C);
        for (int k = 0; k < 4; k++) step(0, 2'b00, 1, 3'(k), 0);   // R2
        step(0, 2'b00, 1, 3'd7, 0);          // R7 code 7
        step(0, 2'b00, 0, 3'd4, 8'h55);      // R7 go low
        step(0, 2'b11, 1, 3'd4, 0);          // R10 with op same edge
        step(0, 2'b11, 0, 3'd0, 0);          // R10
        for (int n = 0; n < 600; n++) begin
            step(1'($urandom), 2'($urandom), 1'($urandom), 3'($urandom), 8'($urandom));
        end
        step(0, 2'b00, 1, 3'd4, 0);
        do_reset();                          // R1 mid-run
        step(0, 2'b10, 0, 3'd0, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule